// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte Queues

This block is a serial peripheral master that software drives through a 32-bit register port. Bytes written to the transmit data register go into a transmit queue. While the master inhibit control bit is clear, the block takes queued bytes one at a time and shifts each out on MOSI. At the same time it shifts a reply byte in from MISO and stores it in a receive queue, which software drains through the receive data register. Separate registers report the status flags and the fill level of each queue. Another register drives the active-low slave-select lines directly.

The serial link runs in mode 0: SCLK idles low, data is sampled on the rising edge and changed on the falling edge, and the most significant bit goes first. Each SCLK half period lasts a parameter's worth of system clocks. Three single-cycle event strobes go to an interrupt controller: the transmit queue ran dry, the receive queue filled up, and a reply byte was lost. Writing a key value to the soft-reset register returns the whole block to its reset state. The two queue-clear control bits act only on the write that carries them.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, status reads 0x5, control reads 0, the select register reads all ones, every `spi_ss_n` line is high, both occupancy registers read 0 and no event strobe is high.
- R2: Register byte offsets are 0x40 soft reset, 0x60 control, 0x64 status, 0x68 transmit data, 0x6C receive data, 0x70 slave select, 0x74 transmit occupancy and 0x78 receive occupancy. Read data and `reg_rvalid` appear on the second rising edge after `reg_rd` is sampled. Any other offset reads 0.
- R3: A read of the receive data register while the receive queue is empty returns 0xDEADBEEF and leaves the queue and the status unchanged.
- R4: Status bit 0 is receive empty, bit 1 receive full, bit 2 transmit empty and bit 3 transmit full, with all other bits 0. A write to the status register changes nothing.
- R5: While control bit 8 (master inhibit) is set, no queued byte is shifted. Clearing the bit starts draining the bytes that are waiting.
- R6: Each byte is shifted MSB first in mode 0, with eight SCLK pulses and each SCLK half period lasting CLK_HALF clocks. Only bits 7:0 of a transmit data write are sent.
- R7: The byte shifted in during each transfer is appended to the receive queue, and reads return these bytes in arrival order.
- R8: A reply byte that arrives while the receive queue holds DEPTH bytes is dropped and pulses `ev_rx_overrun` for one cycle. `ev_rx_full` pulses once when the queue becomes full.
- R9: Writing control bit 5 empties the transmit queue and writing bit 6 empties the receive queue. Neither bit is stored: control reads back only bit 8.
- R10: Writing exactly 0xA to the soft-reset register restores the R1 state. Any other value written there has no effect.
- R11: `spi_ss_n[i]` is low exactly when bit i of the select register is 0, and the register reads back what was written.
- R12: Each occupancy register reads the number of bytes in its queue minus one, or 0 when the queue is empty.
- R13: `ev_tx_empty` pulses once, one cycle after the last queued byte finishes shifting.
- R14: A transmit data write made while the transmit queue holds DEPTH bytes is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NUM_SS | Active-low slave selects |
| ev_tx_empty | output | 1 | Transmit queue drained strobe |
| ev_rx_full | output | 1 | Receive queue became full strobe |
| ev_rx_overrun | output | 1 | Reply byte dropped strobe |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume the bench never issues a soft reset or a queue clear in the cycle it reads receive data. The stimulus follows both rules because every access goes through a task that raises one strobe for one cycle and lowers it before the next access. The bench's slave model also assumes that no soft reset lands in the middle of a byte, so the stimulus waits for each drain to finish before it resets or clears anything.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [6:0] A_SRST  = 7'h40;
  localparam logic [6:0] A_CTRL  = 7'h60;
  localparam logic [6:0] A_STAT  = 7'h64;
  localparam logic [6:0] A_TXD   = 7'h68;
  localparam logic [6:0] A_RXD   = 7'h6C;
  localparam logic [6:0] A_SEL   = 7'h70;
  localparam logic [6:0] A_TXOCC = 7'h74;
  localparam logic [6:0] A_RXOCC = 7'h78;

  localparam logic [31:0] SRST_KEY   = 32'h0000_000A;
  localparam logic [31:0] EMPTY_WORD = 32'hDEAD_BEEF;

  localparam int CB_TXCLR = 5;
  localparam int CB_RXCLR = 6;
  localparam int CB_INH   = 8;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R12: the level cannot rise without a push
  a_r12_no_growth_without_push: assert property (@(posedge clk) disable iff (rst)
    (!clr && !push) |=> (count <= $past(count)));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int CLK_HALF = 2,
  localparam int DIVW    = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  logic [DIVW-1:0] div;
  logic [3:0]      phase;
  logic [7:0]      sh_tx, sh_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      div     <= '0;
      phase   <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          sh_tx <= tx_byte;
          mosi  <= tx_byte[7];
          sclk  <= 1'b0;
          div   <= '0;
          phase <= '0;
        end
      end else if (div == DIVW'(CLK_HALF - 1)) begin
        div   <= '0;
        phase <= phase + 1'b1;
        if (!phase[0]) begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (phase == 4'd15) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_byte <= sh_rx;
          end else begin
            sh_tx <= {sh_tx[6:0], 1'b0};
            mosi  <= sh_tx[6];
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  // R6: the serial clock idles low in mode 0
  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  // R6: one completion strobe per byte
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int NUM_SS   = 2,
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_SS-1:0] spi_ss_n,
  output logic              ev_tx_empty,
  output logic              ev_rx_full,
  output logic              ev_rx_overrun
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          sw_rst, blk_rst, wr_ctrl;
  logic          tx_clr, rx_clr, tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0]    tx_dout, rx_dout, rx_byte;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_empty, tx_full, rx_empty, rx_full, rx_full_q;
  logic          inhibit, load_q, busy, done;
  logic [NUM_SS-1:0] sel_q;

  logic          rd_q, rd_rxd_q, rd_empty_q;
  logic [31:0]   snap, snap_q;

  assign sw_rst  = reg_wr && (reg_addr == A_SRST) && (reg_wdata == SRST_KEY);
  assign blk_rst = rst || sw_rst;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign tx_clr  = wr_ctrl && reg_wdata[CB_TXCLR];
  assign rx_clr  = wr_ctrl && reg_wdata[CB_RXCLR];
  assign tx_push = reg_wr && (reg_addr == A_TXD);
  assign tx_pop  = !inhibit && !tx_empty && !busy && !load_q;
  assign rx_push = done && !rx_full;
  assign rx_pop  = reg_rd && (reg_addr == A_RXD) && !rx_empty;

  spim_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(blk_rst), .clr(tx_clr), .push(tx_push), .din(reg_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(blk_rst), .clr(rx_clr), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .empty(rx_empty), .full(rx_full));

  spim_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
    .clk(clk), .rst(blk_rst), .start(load_q), .tx_byte(tx_dout), .busy(busy),
    .done(done), .rx_byte(rx_byte), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

  // control, select and event registers
  always_ff @(posedge clk) begin
    if (blk_rst) begin
      inhibit       <= 1'b0;
      sel_q         <= '1;
      load_q        <= 1'b0;
      rx_full_q     <= 1'b0;
      ev_tx_empty   <= 1'b0;
      ev_rx_full    <= 1'b0;
      ev_rx_overrun <= 1'b0;
    end else begin
      if (wr_ctrl) inhibit <= reg_wdata[CB_INH];
      if (reg_wr && (reg_addr == A_SEL)) sel_q <= reg_wdata[NUM_SS-1:0];
      load_q        <= tx_pop;
      rx_full_q     <= rx_full;
      ev_tx_empty   <= done && tx_empty && !load_q;
      ev_rx_full    <= rx_full && !rx_full_q;
      ev_rx_overrun <= done && rx_full;
    end
  end

  assign spi_ss_n = sel_q;

  // read pipeline: stage 1 snapshots, stage 2 drives the port
  always_comb begin
    snap = '0;
    case (reg_addr)
      A_CTRL:  snap[CB_INH] = inhibit;
      A_STAT:  snap[3:0] = {tx_full, tx_empty, rx_full, rx_empty};
      A_SEL:   snap[NUM_SS-1:0] = sel_q;
      A_TXOCC: snap = tx_empty ? '0 : 32'(tx_cnt - 1'b1);
      A_RXOCC: snap = rx_empty ? '0 : 32'(rx_cnt - 1'b1);
      default: snap = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (blk_rst) begin
      rd_q       <= 1'b0;
      rd_rxd_q   <= 1'b0;
      rd_empty_q <= 1'b0;
      snap_q     <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      rd_q       <= reg_rd;
      rd_rxd_q   <= reg_rd && (reg_addr == A_RXD);
      rd_empty_q <= rx_empty;
      snap_q     <= snap;
      reg_rvalid <= rd_q;
      if (rd_q)
        reg_rdata <= rd_rxd_q ? (rd_empty_q ? EMPTY_WORD : {24'b0, rx_dout}) : snap_q;
    end
  end

  // R3: a read of an empty receive queue leaves its level alone
  a_r3_empty_read_keeps_level: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == A_RXD) && rx_empty && !done && !rx_clr && !sw_rst)
      |=> (rx_cnt == '0));
  // R5: with inhibit set and nothing in flight, the engine stays idle
  a_r5_inhibit_holds_idle: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !busy && !load_q && !sw_rst) |=> !busy);
  // R10: the key value returns every select line high
  a_r10_soft_reset_selects: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (&spi_ss_n));
endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  localparam time TCLK   = 10ns;
  localparam int  DEPTH  = 256;
  localparam int  NSS    = 2;
  localparam int  HALF   = 2;
  localparam int  BYTE_T = 16 * HALF + 8;

  // {write value, expected MOSI byte}
  localparam logic [39:0] VEC [8] = '{
    {32'h0000_00A5, 8'hA5}, {32'hFFFF_FF00, 8'h00}, {32'h1234_5681, 8'h81},
    {32'h0000_007E, 8'h7E}, {32'h8000_0001, 8'h01}, {32'hCAFE_F00D, 8'h0D},
    {32'h0000_00FF, 8'hFF}, {32'h5555_5533, 8'h33}};

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid, spi_sclk, spi_mosi, spi_miso;
  logic [NSS-1:0] spi_ss_n;
  logic ev_tx_empty, ev_rx_full, ev_rx_overrun;

  int total = 0, bad = 0;
  int n_txe = 0, n_rxf = 0, n_ovr = 0;
  int nbyte = 0, slv_idx = 0, bitcnt = 0;
  logic [7:0] cap = '0, sh;
  logic [7:0] mosi_log [512];
  int sent = 0;

  always #(TCLK/2) clk = ~clk;

  spi_fifo_master #(.DEPTH(DEPTH), .NUM_SS(NSS), .CLK_HALF(HALF)) i_spi_fifo_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n),
    .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full), .ev_rx_overrun(ev_rx_overrun));

  function automatic logic [7:0] resp(int k);
    return 8'(k * 29 + 8'h5A);
  endfunction

  // slave model: captures MOSI on rising SCLK, drives MISO MSB first
  initial begin
    sh = resp(0);
    spi_miso = sh[7];
  end
  always @(posedge spi_sclk) begin
    cap = {cap[6:0], spi_mosi};
    bitcnt++;
    if (bitcnt == 8) begin
      mosi_log[nbyte % 512] = cap;
      nbyte++;
      bitcnt = 0;
    end
  end
  always @(negedge spi_sclk) begin
    if (bitcnt == 0) begin
      slv_idx++;
      sh = resp(slv_idx);
    end else sh = {sh[6:0], 1'b0};
    spi_miso = sh[7];
  end

  always @(posedge clk) begin
    if (ev_tx_empty)   n_txe++;
    if (ev_rx_full)    n_rxf++;
    if (ev_rx_overrun) n_ovr++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    @(negedge clk);
    d = reg_rdata;
    if (!reg_rvalid) chk("R2 rvalid", {31'b0, reg_rvalid}, 32'h1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base, n0, t0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(7'h64, d); chk("R1 status", d, 32'h5);
    rd(7'h60, d); chk("R1 control", d, 32'h0);
    rd(7'h70, d); chk("R1 select reg", d, 32'h3);
    chk("R1 ss_n", 32'(spi_ss_n), 32'h3);
    rd(7'h74, d); chk("R1 tx occ", d, 0);
    rd(7'h78, d); chk("R1 rx occ", d, 0);
    chk("R1 events", {29'b0, ev_tx_empty, ev_rx_full, ev_rx_overrun}, 0);
    rd(7'h7C, d); chk("R2 unmapped", d, 0);

    // R6 R7 table walk
    for (int i = 0; i < 8; i++) begin
      wr(7'h68, VEC[i][39:8]);
      idle(BYTE_T);
      chk("R6 mosi byte", 32'(mosi_log[sent % 512]), 32'(VEC[i][7:0]));
      rd(7'h6C, d); chk("R7 rx byte", d, 32'(resp(sent)));
      sent++;
    end
    chk("R13 tx_empty per byte", n_txe, 8);

    // R3 sentinel on empty read
    rd(7'h6C, d); chk("R3 sentinel", d, 32'hDEADBEEF);
    rd(7'h64, d); chk("R3 status kept", d, 32'h5);
    rd(7'h78, d); chk("R3 rx occ kept", d, 0);

    // R4 status write ignored
    wr(7'h64, 32'hFFFF_FFFF);
    rd(7'h64, d); chk("R4 status write", d, 32'h5);

    // R5 inhibit gating, R12 occupancy
    wr(7'h60, 32'h100);
    rd(7'h60, d); chk("R9 control readback", d, 32'h100);
    n0 = nbyte;
    wr(7'h68, 32'h11); wr(7'h68, 32'h22); wr(7'h68, 32'h33);
    idle(3 * BYTE_T);
    chk("R5 no shift while inhibited", nbyte, n0);
    rd(7'h74, d); chk("R12 tx occ", d, 2);
    rd(7'h64, d); chk("R4 tx not empty", d, 32'h1);
    t0 = n_txe;
    wr(7'h60, 32'h0);
    idle(3 * BYTE_T);
    chk("R5 drained after release", nbyte, n0 + 3);
    chk("R13 single tx_empty", n_txe, t0 + 1);
    rd(7'h78, d); chk("R12 rx occ", d, 2);
    rd(7'h6C, d); chk("R7 order first", d, 32'(resp(sent)));
    rd(7'h6C, d); chk("R7 order second", d, 32'(resp(sent + 1)));
    sent += 3;

    // R9 queue clears
    wr(7'h60, 32'h40);
    rd(7'h78, d); chk("R9 rx clear", d, 0);
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h44); wr(7'h68, 32'h55);
    wr(7'h60, 32'h120);
    rd(7'h74, d); chk("R9 tx clear", d, 0);
    rd(7'h60, d); chk("R9 clear bits not stored", d, 32'h100);
    rd(7'h64, d); chk("R9 status after clears", d, 32'h5);

    // R14 R8 fill both queues
    for (int i = 0; i < DEPTH + 1; i++) wr(7'h68, 32'(i));
    rd(7'h74, d); chk("R14 tx occ capped", d, DEPTH - 1);
    rd(7'h64, d); chk("R4 tx full", d, 32'h9);
    base = sent;
    wr(7'h60, 32'h0);
    idle(DEPTH * BYTE_T);
    sent += DEPTH;
    rd(7'h64, d); chk("R4 rx full", d, 32'h6);
    chk("R8 full strobe", n_rxf, 1);
    chk("R8 no overrun yet", n_ovr, 0);
    wr(7'h68, 32'hAB);
    idle(BYTE_T);
    sent++;
    chk("R8 overrun strobe", n_ovr, 1);
    rd(7'h78, d); chk("R8 rx occ after drop", d, DEPTH - 1);
    rd(7'h6C, d); chk("R8 oldest kept", d, 32'(resp(base)));
    wr(7'h60, 32'h40);

    // R11 selects
    wr(7'h70, 32'h2);
    chk("R11 ss_n", 32'(spi_ss_n), 32'h2);
    rd(7'h70, d); chk("R11 readback", d, 32'h2);

    // R10 soft reset
    wr(7'h60, 32'h100);
    wr(7'h40, 32'h5);
    rd(7'h70, d); chk("R10 wrong key ignored", d, 32'h2);
    rd(7'h60, d); chk("R10 wrong key control", d, 32'h100);
    wr(7'h40, 32'hA);
    chk("R10 ss_n released", 32'(spi_ss_n), 32'h3);
    rd(7'h60, d); chk("R10 control cleared", d, 0);
    rd(7'h64, d); chk("R10 status", d, 32'h5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule